// File: doc/BRIEF.md
# Word ALU with Per-Opcode Flag Rules

This block is the purely combinational execution stage of a small W-bit register machine. Each cycle it receives a 5-bit opcode, a first operand `src_a` and a second operand `src_b`. The first operand is the source register value, or the destination's current value for compares and conditional moves. The block also receives the machine's current condition flag. It returns a W-bit result, a write-enable for the destination register and the next value of the flag.

It covers four families of operation:
- bitwise logic;
- add and subtract;
- three multiplies;
- logical shifts.

It also provides five comparisons and two moves. Every opcode defines the flag in its own way: zero detection, carry, inverted borrow, unsigned or signed multiply overflow, the edge bit of the shifted word, or a comparison outcome. The moves leave the flag as it was. The register file, the program counter and any memory sit outside the block.

Top module: `wordalu`

## Requirements
- R1: Opcodes and=0, or=1, xor=2 and not=3 write `src_a` AND, OR or XOR `src_b`, or (for not) the complement of `src_b`. `wr_en` is 1, and `flag_out` is 1 exactly when the W-bit result is zero.
- R2: Opcode add=4 writes the low W bits of `src_a + src_b`, and `flag_out` is the carry out of bit W-1.
- R3: Opcode sub=5 writes `src_a - src_b` modulo 2^W, and `flag_out` is 1 exactly when `src_a < src_b` as unsigned numbers.
- R4: Opcode mull=6 writes the low W bits of the unsigned 2W-bit product, and opcode umulh=7 writes its high W bits. For both, `flag_out` is 1 when that product exceeds 2^W-1.
- R5: Opcode smulh=8 writes the high W bits of the signed two's-complement 2W-bit product. `flag_out` is 1 when that product lies outside -2^(W-1) to 2^(W-1)-1.
- R6: Opcodes shl=9 and shr=10 shift `src_a` left or right by the unsigned value of `src_b`, filling with zeros. A shift amount of W or more gives zero. `flag_out` is bit W-1 of `src_a` for shl and bit 0 of `src_a` for shr.
- R7: Opcodes cmpe=11, cmpa=12, cmpae=13, cmpg=14 and cmpge=15 set `flag_out` to the outcome of the test `src_a` vs `src_b`. The tests are, in that order: equal, unsigned greater, unsigned greater-or-equal, signed greater, and signed greater-or-equal. For these opcodes `wr_en` is 0 and `result` is 0.
- R8: Opcode mov=16 writes `src_b` with `wr_en` 1, and `flag_out` equals `flag_in`.
- R9: Opcode cmov=17 drives `result` to `src_b` when `flag_in` is 1 and to `src_a` when it is 0, with `wr_en` 1, and `flag_out` equals `flag_in`.
- R10: Any opcode from 18 to 31 drives `wr_en` 0 and `result` 0, and `flag_out` equals `flag_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_code | input | 5 | Operation select |
| src_a | input | W | First operand (source, or destination's current value) |
| src_b | input | W | Second operand (register or immediate) |
| flag_in | input | 1 | Current condition flag |
| result | output | W | Value for the destination register |
| wr_en | output | 1 | Destination write-enable |
| flag_out | output | 1 | Next condition flag |

## Verification
The bench builds the block with W=8, so that every opcode code 0 to 31 is swept against operands on the sign and carry boundaries. The sweep includes 0x7F, 0x80 and 0xFF, and a shift amount of 8 or more lies within the range of `src_b`. At this width, a 16-bit product of -128 by -128 makes signed-overflow edges and the smallest unsigned-overflow product easy to write down by hand, and integer arithmetic in the bench can recompute every product.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [4:0] {
    OP_AND   = 5'd0,
    OP_OR    = 5'd1,
    OP_XOR   = 5'd2,
    OP_NOT   = 5'd3,
    OP_ADD   = 5'd4,
    OP_SUB   = 5'd5,
    OP_MULL  = 5'd6,
    OP_UMULH = 5'd7,
    OP_SMULH = 5'd8,
    OP_SHL   = 5'd9,
    OP_SHR   = 5'd10,
    OP_CMPE  = 5'd11,
    OP_CMPA  = 5'd12,
    OP_CMPAE = 5'd13,
    OP_CMPG  = 5'd14,
    OP_CMPGE = 5'd15,
    OP_MOV   = 5'd16,
    OP_CMOV  = 5'd17
  } op_e;

  function automatic logic is_compare(input logic [4:0] op);
    return (op >= 5'd11) && (op <= 5'd15);
  endfunction

  function automatic logic is_known(input logic [4:0] op);
    return op <= 5'd17;
  endfunction
endpackage

// File: rtl/wa_logic.sv
module wa_logic import alu_pkg::*; #(
  parameter int W = 16
) (
  input  logic [4:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res,
  output logic         zero
);
  always_comb begin
    unique case (op)
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_NOT:  res = ~b;
      default: res = '0;
    endcase
  end

  assign zero = ~|res;

  always_comb begin
    if (op == OP_NOT)
      AST_NOT_ZERO_ONES: assert (zero == (&b)) else $error("not flag"); // R1
  end
endmodule

// File: rtl/wa_arith.sv
module wa_arith import alu_pkg::*; #(
  parameter int W = 16
) (
  input  logic [4:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res,
  output logic         flag
);
  localparam int W2 = 2 * W;

  function automatic logic [W:0] add_wide(input logic [W-1:0] x, input logic [W-1:0] y);
    return {1'b0, x} + {1'b0, y};
  endfunction

  function automatic logic [W:0] sub_biased(input logic [W-1:0] x, input logic [W-1:0] y);
    return {1'b1, x} - {1'b0, y};
  endfunction

  function automatic logic [W2-1:0] umul(input logic [W-1:0] x, input logic [W-1:0] y);
    return {{W{1'b0}}, x} * {{W{1'b0}}, y};
  endfunction

  function automatic logic [W2-1:0] smul(input logic [W-1:0] x, input logic [W-1:0] y);
    return $unsigned($signed({{W{x[W-1]}}, x}) * $signed({{W{y[W-1]}}, y}));
  endfunction

  logic [W:0]    sum_w;
  logic [W:0]    dif_w;
  logic [W2-1:0] uprod;
  logic [W2-1:0] sprod;
  logic          u_ovf;
  logic          s_ovf;

  assign sum_w = add_wide(a, b);
  assign dif_w = sub_biased(a, b);
  assign uprod = umul(a, b);
  assign sprod = smul(a, b);
  assign u_ovf = |uprod[W2-1:W];
  assign s_ovf = !((&sprod[W2-1:W-1]) || (~|sprod[W2-1:W-1]));

  always_comb begin
    res  = '0;
    flag = 1'b0;
    unique case (op)
      OP_ADD:   begin res = sum_w[W-1:0];      flag = sum_w[W];  end
      OP_SUB:   begin res = dif_w[W-1:0];      flag = ~dif_w[W]; end
      OP_MULL:  begin res = uprod[W-1:0];      flag = u_ovf;     end
      OP_UMULH: begin res = uprod[W2-1:W];     flag = u_ovf;     end
      OP_SMULH: begin res = sprod[W2-1:W];     flag = s_ovf;     end
      default:  begin res = '0;                flag = 1'b0;      end
    endcase
  end

  always_comb begin
    if (op == OP_ADD)
      AST_ADD_CARRY: assert (flag == (res < a)) else $error("carry"); // R2
    if (op == OP_SUB)
      AST_SUB_BORROW: assert (flag == (res > a)) else $error("borrow"); // R3
    if (op == OP_MULL && flag)
      AST_MUL_NONZERO: assert (a != '0 && b != '0) else $error("mul ovf"); // R4
    if (op == OP_SMULH && !flag)
      AST_SMULH_FITS: assert ((res == '0) || (&res)) else $error("smulh fit"); // R5
  end
endmodule

// File: rtl/wa_shift.sv
module wa_shift import alu_pkg::*; #(
  parameter int W = 16
) (
  input  logic [4:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res,
  output logic         flag
);
  localparam logic [W:0] LIMIT = (W + 1)'(W);

  logic too_far;
  assign too_far = {1'b0, b} >= LIMIT;

  always_comb begin
    res  = '0;
    flag = 1'b0;
    if (op == OP_SHL) begin
      res  = too_far ? '0 : (a << b);
      flag = a[W-1];
    end else if (op == OP_SHR) begin
      res  = too_far ? '0 : (a >> b);
      flag = a[0];
    end
  end

  always_comb begin
    if (too_far)
      AST_SHIFT_WIDE_ZERO: assert (res == '0) else $error("wide shift"); // R6
    if (op == OP_SHR && b == '0)
      AST_SHR_IDENTITY: assert (res == a) else $error("shr by 0"); // R6
  end
endmodule

// File: rtl/wa_cmp.sv
module wa_cmp import alu_pkg::*; #(
  parameter int W = 16
) (
  input  logic [4:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         flag
);
  logic eq, gt_u, ge_u, gt_s, ge_s;

  assign eq   = (a == b);
  assign gt_u = (a > b);
  assign ge_u = (a >= b);
  assign gt_s = ($signed(a) > $signed(b));
  assign ge_s = ($signed(a) >= $signed(b));

  always_comb begin
    unique case (op)
      OP_CMPE:  flag = eq;
      OP_CMPA:  flag = gt_u;
      OP_CMPAE: flag = ge_u;
      OP_CMPG:  flag = gt_s;
      OP_CMPGE: flag = ge_s;
      default:  flag = 1'b0;
    endcase
  end

  always_comb begin
    AST_EQ_FROM_ORDER: assert (eq == (ge_u && !gt_u)) else $error("eq"); // R7
    AST_SIGNED_ORDER: assert (ge_s == (gt_s || eq)) else $error("ge_s"); // R7
  end
endmodule

// File: rtl/wordalu.sv
module wordalu import alu_pkg::*; #(
  parameter int W = 16
) (
  input  logic [4:0]   op_code,
  input  logic [W-1:0] src_a,
  input  logic [W-1:0] src_b,
  input  logic         flag_in,
  output logic [W-1:0] result,
  output logic         wr_en,
  output logic         flag_out
);
  logic [W-1:0] lg_res, ar_res, sh_res;
  logic         lg_zero, ar_flag, sh_flag, cmp_flag;

  wa_logic #(.W(W)) u_logic (.op(op_code), .a(src_a), .b(src_b), .res(lg_res), .zero(lg_zero));
  wa_arith #(.W(W)) u_arith (.op(op_code), .a(src_a), .b(src_b), .res(ar_res), .flag(ar_flag));
  wa_shift #(.W(W)) u_shift (.op(op_code), .a(src_a), .b(src_b), .res(sh_res), .flag(sh_flag));
  wa_cmp   #(.W(W)) u_cmp   (.op(op_code), .a(src_a), .b(src_b), .flag(cmp_flag));

  always_comb begin
    result   = '0;
    wr_en    = 1'b0;
    flag_out = flag_in;
    unique case (op_code)
      OP_AND, OP_OR, OP_XOR, OP_NOT: begin
        result = lg_res; wr_en = 1'b1; flag_out = lg_zero;
      end
      OP_ADD, OP_SUB, OP_MULL, OP_UMULH, OP_SMULH: begin
        result = ar_res; wr_en = 1'b1; flag_out = ar_flag;
      end
      OP_SHL, OP_SHR: begin
        result = sh_res; wr_en = 1'b1; flag_out = sh_flag;
      end
      OP_CMPE, OP_CMPA, OP_CMPAE, OP_CMPG, OP_CMPGE: begin
        flag_out = cmp_flag;
      end
      OP_MOV: begin
        result = src_b; wr_en = 1'b1;
      end
      OP_CMOV: begin
        result = flag_in ? src_b : src_a; wr_en = 1'b1;
      end
      default: ;
    endcase
  end

  always_comb begin
    if (is_compare(op_code))
      AST_CMP_NO_WRITE: assert (!wr_en && result == '0) else $error("cmp write"); // R7
    if (!is_known(op_code))
      AST_BAD_OP_HOLD: assert (!wr_en && flag_out == flag_in) else $error("bad op"); // R10
    if (op_code == OP_MOV)
      AST_MOV_KEEPS_FLAG: assert (flag_out == flag_in && result == src_b) else $error("mov"); // R8
    if (op_code == OP_CMOV)
      AST_CMOV_SELECT: assert (flag_out == flag_in && (flag_in ? result == src_b : result == src_a))
        else $error("cmov"); // R9
  end
endmodule

// File: tb/sim_wordalu.sv
module sim_wordalu;
  localparam int W = 8;
  localparam int NV = 17;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [4:0]   op_code = '0;
  logic [W-1:0] src_a = '0;
  logic [W-1:0] src_b = '0;
  logic         flag_in = 1'b0;
  logic [W-1:0] result;
  logic         wr_en;
  logic         flag_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  wordalu #(.W(W)) u0 (.*);

  // fields: op[31:27] a[26:19] b[18:11] fin[10] res[9:2] we[1] flag[0]
  localparam logic [31:0] VEC [NV] = '{
    {5'd4,  8'hFF, 8'h01, 1'b0, 8'h00, 1'b1, 1'b1},
    {5'd5,  8'h03, 8'h05, 1'b0, 8'hFE, 1'b1, 1'b1},
    {5'd5,  8'h05, 8'h05, 1'b1, 8'h00, 1'b1, 1'b0},
    {5'd6,  8'h10, 8'h10, 1'b0, 8'h00, 1'b1, 1'b1},
    {5'd7,  8'h10, 8'h10, 1'b0, 8'h01, 1'b1, 1'b1},
    {5'd8,  8'hFF, 8'hFF, 1'b1, 8'h00, 1'b1, 1'b0},
    {5'd8,  8'h80, 8'h80, 1'b0, 8'h40, 1'b1, 1'b1},
    {5'd8,  8'h80, 8'h01, 1'b0, 8'hFF, 1'b1, 1'b0},
    {5'd9,  8'h81, 8'h01, 1'b0, 8'h02, 1'b1, 1'b1},
    {5'd9,  8'h81, 8'h08, 1'b0, 8'h00, 1'b1, 1'b1},
    {5'd10, 8'h81, 8'h07, 1'b0, 8'h01, 1'b1, 1'b1},
    {5'd14, 8'h01, 8'hFF, 1'b0, 8'h00, 1'b0, 1'b1},
    {5'd12, 8'h01, 8'hFF, 1'b1, 8'h00, 1'b0, 1'b0},
    {5'd17, 8'h33, 8'h44, 1'b0, 8'h33, 1'b1, 1'b0},
    {5'd31, 8'h12, 8'h34, 1'b1, 8'h00, 1'b0, 1'b1},
    {5'd2,  8'h5A, 8'h5A, 1'b0, 8'h00, 1'b1, 1'b1},
    {5'd3,  8'h00, 8'hFF, 1'b0, 8'h00, 1'b1, 1'b1}
  };

  function automatic string tag(input int op);
    if (op <= 3) return "R1";
    if (op == 4) return "R2";
    if (op == 5) return "R3";
    if (op == 6 || op == 7) return "R4";
    if (op == 8) return "R5";
    if (op == 9 || op == 10) return "R6";
    if (op <= 15) return "R7";
    if (op == 16) return "R8";
    if (op == 17) return "R9";
    return "R10";
  endfunction

  // Independent integer model: returns {res, we, flag}
  function automatic logic [9:0] model(input int op, input int a, input int b, input bit fin);
    int r, p, sa, sb;
    bit we, f;
    r = 0; we = 1; f = fin;
    sa = (a >= 128) ? a - 256 : a;
    sb = (b >= 128) ? b - 256 : b;
    case (op)
      0: begin r = a & b; f = (r == 0); end
      1: begin r = a | b; f = (r == 0); end
      2: begin r = a ^ b; f = (r == 0); end
      3: begin r = 255 - b; f = (r == 0); end
      4: begin r = (a + b) % 256; f = (a + b) > 255; end
      5: begin r = (a - b + 256) % 256; f = a < b; end
      6: begin p = a * b; r = p % 256; f = p > 255; end
      7: begin p = a * b; r = p / 256; f = p > 255; end
      8: begin p = sa * sb; r = ((p + 65536) / 256) % 256; f = (p < -128) || (p > 127); end
      9: begin r = (b >= 8) ? 0 : (a * (1 << b)) % 256; f = a >= 128; end
      10: begin r = (b >= 8) ? 0 : a / (1 << b); f = (a % 2) == 1; end
      11: begin we = 0; f = (a == b); end
      12: begin we = 0; f = (a > b); end
      13: begin we = 0; f = (a >= b); end
      14: begin we = 0; f = (sa > sb); end
      15: begin we = 0; f = (sa >= sb); end
      16: r = b;
      17: r = fin ? b : a;
      default: we = 0;
    endcase
    return {r[7:0], we, f};
  endfunction

  task automatic apply_check(input int op, input int a, input int b, input bit fin,
                             input logic [9:0] exp, input string req);
    op_code = op[4:0]; src_a = a[7:0]; src_b = b[7:0]; flag_in = fin;
    #3;
    checks++;
    if ({result, wr_en, flag_out} !== exp) begin
      errors++;
      $display("FAIL %s op=%0d a=%h b=%h fin=%b actual res=%h we=%b f=%b expected res=%h we=%b f=%b",
               req, op, a, b, fin, result, wr_en, flag_out, exp[9:2], exp[1], exp[0]);
    end
    #2;
  endtask

  localparam int NS = 8;
  localparam int SAMP [NS] = '{0, 1, 2, 7, 8, 127, 128, 255};

  initial begin
    repeat (2) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // initial state: and of zeros gives zero, flag set (R1)
    apply_check(0, 0, 0, 0, {8'h00, 1'b1, 1'b1}, "R1");
    // vector table
    for (int i = 0; i < NV; i++) begin
      apply_check(int'(VEC[i][31:27]), int'(VEC[i][26:19]), int'(VEC[i][18:11]),
                  VEC[i][10], VEC[i][9:0], tag(int'(VEC[i][31:27])));
    end
    // directed: mov leaves flag both ways (R8), unknown op holds flag 0 (R10)
    apply_check(16, 8'h11, 8'hA5, 1, {8'hA5, 1'b1, 1'b1}, "R8");
    apply_check(16, 8'h11, 8'hA5, 0, {8'hA5, 1'b1, 1'b0}, "R8");
    apply_check(18, 8'hFF, 8'hFF, 0, {8'h00, 1'b0, 1'b0}, "R10");
    apply_check(17, 8'h33, 8'h44, 1, {8'h44, 1'b1, 1'b1}, "R9");
    apply_check(10, 8'hFF, 8'hC8, 0, {8'h00, 1'b1, 1'b1}, "R6");
    apply_check(15, 8'h80, 8'h80, 0, {8'h00, 1'b0, 1'b1}, "R7");
    // sweep every opcode over boundary operands
    for (int op = 0; op < 32; op++)
      for (int ia = 0; ia < NS; ia++)
        for (int ib = 0; ib < NS; ib++)
          for (int fi = 0; fi < 2; fi++)
            apply_check(op, SAMP[ia], SAMP[ib], fi[0],
                        model(op, SAMP[ia], SAMP[ib], fi[0]), tag(op));
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule